// File: doc/BRIEF.md
# Gamma Correction Lookup Table with Indirect Host Access

This block sits in a pixel output path and remaps each 8-bit colour channel of a 24-bit pixel through a 256-entry lookup table. Each table entry holds a corrected blue, green and red value. The red byte of the pixel selects the entry whose red field is used, and the same holds for green and blue. A single active-low enable input chooses between corrected pixels and the raw input passed straight through.

The host reaches the table through two word-wide registers. One is a pointer register. The other is a data window into the entry that the pointer names. Every data-window read or write moves the pointer on by one, so the host can stream a whole table in without reloading the address. When the host touches the table, the pixel output repeats its last value for one extra dot period. Everything runs on one clock, and a dot-clock enable paces the pixel stream.

Top module: `gamma_lut_top`

## Requirements
- R1: After reset, pix_o is 0, pix_valid_o is 0, host_rdata is 0 and the pointer is 0, so a pointer-register read returns 0.
- R2: A host write with host_sel=0 loads the pointer from host_wdata[7:0]. A pointer-register read (host_sel=0, host_rd=1) returns {24'b0, pointer} on host_rdata one cycle later.
- R3: A host write with host_sel=1 stores blue=host_wdata[31:24], green=[23:16] and red=[15:8] at the pointer, then advances the pointer by one.
- R4: A data read (host_sel=1, host_rd=1, host_wr=0) returns {blue, green, red, 8'h00} of the entry at the pointer on host_rdata one cycle later, then advances the pointer by one.
- R5: The pointer wraps from 255 back to 0 when it advances.
- R6: In a cycle with dot_en=1, tbl_off=0 and no pending host access, the next cycle's pix_o holds table[pix_i[23:16]].blue in [23:16], table[pix_i[15:8]].green in [15:8] and table[pix_i[7:0]].red in [7:0]. pix_valid_o then equals that cycle's pix_valid_i.
- R7: With tbl_off=1, under the same conditions, pix_o equals pix_i one cycle later.
- R8: A host data access (host_sel=1 with host_wr or host_rd) occurs in a dot_en cycle, or occurs after the previous dot_en cycle. In that dot_en cycle, pix_o and pix_valid_o keep their previous values.
- R9: In a cycle with dot_en=0, pix_o and pix_valid_o do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dot_en | input | 1 | Dot-clock enable for the pixel path |
| host_wr | input | 1 | Host write strobe (takes priority over host_rd) |
| host_rd | input | 1 | Host read strobe |
| host_sel | input | 1 | 0 selects the pointer register, 1 selects the data window |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid the cycle after a read |
| tbl_off | input | 1 | Active-low table enable: 0 corrects, 1 bypasses |
| pix_valid_i | input | 1 | Input pixel qualifier |
| pix_i | input | 24 | Input pixel: blue [23:16], green [15:8], red [7:0] |
| pix_valid_o | output | 1 | Output pixel qualifier |
| pix_o | output | 24 | Output pixel, same channel layout |

## Verification
Host read data and the corrected or bypassed pixel each sit one register stage behind the cycle that requested them. The bench therefore drives a stimulus just after a rising edge and compares the output just after the next rising edge. A hold caused by a host access is checked on the edge of the dot period that absorbs it. When the access happens while dot_en is low, the bench checks that the hold lands on the next enabled edge and that new data appears one edge after that. The bench loads the whole table by streaming writes, reads it back in the same way, and then sweeps all 256 byte values through both the corrected path and the bypassed path.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
  localparam int CH_W   = 8;
  localparam int IDX_W  = CH_W;
  localparam int DEPTH  = 1 << IDX_W;
  localparam int WORD_W = 32;
  localparam int PIX_W  = 3 * CH_W;

  typedef struct packed {
    logic [CH_W-1:0] b;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] r;
  } rgb_t;
endpackage

// File: rtl/gamma_host_if.sv
module gamma_host_if
  import gamma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_sel,
  input  logic [WORD_W-1:0] host_wdata,
  input  rgb_t              ram_rdata,
  output logic [IDX_W-1:0]  ptr_q,
  output logic              ram_we,
  output rgb_t              ram_wdata,
  output logic [WORD_W-1:0] host_rdata,
  output logic              data_acc
);
  localparam int PAD_W = WORD_W - IDX_W;
  localparam int LOW_W = WORD_W - PIX_W;

  logic              rd_eff;
  logic [IDX_W-1:0]  ptr_d;
  logic [WORD_W-1:0] rdata_d;

  assign rd_eff    = host_rd & ~host_wr;
  assign data_acc  = host_sel & (host_wr | host_rd);
  assign ram_we    = host_wr & host_sel;
  assign ram_wdata = rgb_t'(host_wdata[WORD_W-1 -: PIX_W]);

  always_comb begin
    ptr_d = ptr_q;
    if (host_wr && !host_sel) ptr_d = host_wdata[IDX_W-1:0];
    else if (data_acc)        ptr_d = ptr_q + 1'b1;
  end

  always_comb begin
    rdata_d = host_rdata;
    if (rd_eff) begin
      if (host_sel) rdata_d = {ram_rdata, {LOW_W{1'b0}}};
      else          rdata_d = {{PAD_W{1'b0}}, ptr_q};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q      <= '0;
      host_rdata <= '0;
    end else begin
      ptr_q      <= ptr_d;
      host_rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/gamma_ram.sv
module gamma_ram
  import gamma_pkg::*;
(
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  rgb_t             wdata,
  input  logic [IDX_W-1:0] haddr,
  output rgb_t             hdata,
  input  rgb_t             pix_idx,
  output rgb_t             lk
);
  rgb_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign hdata = mem[haddr];

  always_comb begin
    lk.b = mem[pix_idx.b].b;
    lk.g = mem[pix_idx.g].g;
    lk.r = mem[pix_idx.r].r;
  end
endmodule

// File: rtl/gamma_pix_path.sv
module gamma_pix_path
  import gamma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dot_en,
  input  logic acc,
  input  logic tbl_off,
  input  logic valid_i,
  input  rgb_t pix_i,
  input  rgb_t lk,
  output rgb_t pix_o,
  output logic valid_o,
  output logic stall
);
  logic pend_q, pend_d;
  rgb_t pix_d;
  logic valid_d;

  assign stall = acc | pend_q;

  always_comb begin
    pend_d  = dot_en ? 1'b0 : (pend_q | acc);
    pix_d   = pix_o;
    valid_d = valid_o;
    if (dot_en && !stall) begin
      pix_d   = tbl_off ? pix_i : lk;
      valid_d = valid_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      pix_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      pix_o   <= pix_d;
      valid_o <= valid_d;
    end
  end
endmodule

// File: rtl/gamma_lut_top.sv
module gamma_lut_top
  import gamma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dot_en,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_sel,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  input  logic              tbl_off,
  input  logic              pix_valid_i,
  input  logic [PIX_W-1:0]  pix_i,
  output logic              pix_valid_o,
  output logic [PIX_W-1:0]  pix_o
);
  logic [1:0]       rst_sync;
  logic             rst_q_n;
  logic [IDX_W-1:0] ptr_q;
  logic             ram_we;
  rgb_t             ram_wdata;
  rgb_t             ram_hdata;
  rgb_t             lk;
  rgb_t             pix_out_s;
  logic             data_acc;
  logic             stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  gamma_host_if u_host (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .ram_rdata  (ram_hdata),
    .ptr_q      (ptr_q),
    .ram_we     (ram_we),
    .ram_wdata  (ram_wdata),
    .host_rdata (host_rdata),
    .data_acc   (data_acc)
  );

  gamma_ram u_ram (
    .clk     (clk),
    .we      (ram_we),
    .waddr   (ptr_q),
    .wdata   (ram_wdata),
    .haddr   (ptr_q),
    .hdata   (ram_hdata),
    .pix_idx (rgb_t'(pix_i)),
    .lk      (lk)
  );

  gamma_pix_path u_pix (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .dot_en  (dot_en),
    .acc     (data_acc),
    .tbl_off (tbl_off),
    .valid_i (pix_valid_i),
    .pix_i   (rgb_t'(pix_i)),
    .lk      (lk),
    .pix_o   (pix_out_s),
    .valid_o (pix_valid_o),
    .stall   (stall)
  );

  assign pix_o = pix_out_s;
endmodule

// File: rtl/gamma_lut_chk.sv
module gamma_lut_chk
  import gamma_pkg::*;
(
  input logic              clk,
  input logic              rst_q_n,
  input logic              dot_en,
  input logic              host_wr,
  input logic              host_rd,
  input logic              host_sel,
  input logic [WORD_W-1:0] host_wdata,
  input logic [WORD_W-1:0] host_rdata,
  input logic              tbl_off,
  input logic [PIX_W-1:0]  pix_i,
  input logic [PIX_W-1:0]  pix_o,
  input logic              pix_valid_o,
  input logic [IDX_W-1:0]  ptr_q,
  input logic              stall
);
  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_q_n)
    host_wr && !host_sel |=> ptr_q == $past(host_wdata[IDX_W-1:0])); // R2

  AST_ADDR_READ_PAD: assert property (@(posedge clk) disable iff (!rst_q_n)
    host_rd && !host_wr && !host_sel |=> host_rdata[WORD_W-1:IDX_W] == '0); // R2

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_q_n)
    host_sel && (host_wr || host_rd) |=> ptr_q == IDX_W'($past(ptr_q) + 1'b1)); // R3

  AST_DATA_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    host_rd && !host_wr && host_sel |=> host_rdata[WORD_W-PIX_W-1:0] == '0); // R4

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_q_n)
    dot_en && tbl_off && !stall |=> pix_o == $past(pix_i)); // R7

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    dot_en && stall |=> $stable(pix_o) && $stable(pix_valid_o)); // R8

  AST_DOT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    !dot_en |=> $stable(pix_o) && $stable(pix_valid_o)); // R9
endmodule

bind gamma_lut_top gamma_lut_chk u_chk (.*);

// File: tb/gamma_lut_top_tb_top.sv
module gamma_lut_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        dot_en, host_wr, host_rd, host_sel, tbl_off, pix_valid_i;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic [23:0] pix_i, pix_o;
  logic        pix_valid_o;
  int          nvec = 0;
  int          nfail = 0;

  always #5 clk = ~clk;

  gamma_lut_top dut_i (
    .clk(clk), .rst_n(rst_n), .dot_en(dot_en),
    .host_wr(host_wr), .host_rd(host_rd), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tbl_off(tbl_off), .pix_valid_i(pix_valid_i), .pix_i(pix_i),
    .pix_valid_o(pix_valid_o), .pix_o(pix_o)
  );

  function automatic logic [23:0] ent(logic [7:0] i);
    ent = {~i, 8'(i * 8'd3 + 8'd7), i ^ 8'hA5};
  endfunction

  function automatic logic [23:0] lut(logic [23:0] p);
    logic [23:0] eb, eg, er;
    eb = ent(p[23:16]);
    eg = ent(p[15:8]);
    er = ent(p[7:0]);
    lut = {eb[23:16], eg[15:8], er[7:0]};
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [23:0] pa, pb, pc;
    rst_n = 1'b0; dot_en = 1'b1; host_wr = 1'b0; host_rd = 1'b0; host_sel = 1'b0;
    host_wdata = '0; tbl_off = 1'b0; pix_valid_i = 1'b0; pix_i = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();

    // R1 reset state
    check("R1 pix_o", {8'h0, pix_o}, 32'h0);
    check("R1 pix_valid_o", {31'h0, pix_valid_o}, 32'h0);
    check("R1 host_rdata", host_rdata, 32'h0);
    host_rd = 1'b1; host_sel = 1'b0; step(); host_rd = 1'b0;
    check("R1 pointer", host_rdata, 32'h0);

    // R2 pointer load and readback, upper write bits ignored
    host_wr = 1'b1; host_sel = 1'b0; host_wdata = 32'hFFFF_FF3C; step(); host_wr = 1'b0;
    host_rd = 1'b1; step(); host_rd = 1'b0;
    check("R2 pointer read", host_rdata, 32'h0000_003C);

    // R3 stream the whole table from entry 0
    host_wr = 1'b1; host_sel = 1'b0; host_wdata = 32'h0; step();
    host_sel = 1'b1;
    for (int i = 0; i < 256; i++) begin
      host_wdata = {ent(8'(i)), 8'h00};
      step();
    end
    host_wr = 1'b0;
    // R5 pointer wrapped after 256 advances
    host_sel = 1'b0; host_rd = 1'b1; step(); host_rd = 1'b0;
    check("R5 wrap after stream", host_rdata, 32'h0);

    // R5 wrap from 254 by rewriting the last two entries
    host_wr = 1'b1; host_sel = 1'b0; host_wdata = 32'h0000_00FE; step();
    host_sel = 1'b1; host_wdata = {ent(8'hFE), 8'h00}; step();
    host_wdata = {ent(8'hFF), 8'h00}; step(); host_wr = 1'b0;
    host_sel = 1'b0; host_rd = 1'b1; step(); host_rd = 1'b0;
    check("R5 wrap 255 to 0", host_rdata, 32'h0);

    // R3 / R4 streamed readback of every entry
    host_rd = 1'b1; host_sel = 1'b1;
    for (int i = 0; i < 256; i++) begin
      step();
      check("R3 readback", host_rdata, {ent(8'(i)), 8'h00});
    end
    host_rd = 1'b0;

    // R4 non-sequential run after a pointer reload
    host_wr = 1'b1; host_sel = 1'b0; host_wdata = 32'h0000_0080; step(); host_wr = 1'b0;
    host_sel = 1'b1; host_rd = 1'b1; step();
    check("R4 read entry 0x80", host_rdata, {ent(8'h80), 8'h00});
    step(); host_rd = 1'b0;
    check("R4 read entry 0x81", host_rdata, {ent(8'h81), 8'h00});
    host_sel = 1'b0; host_rd = 1'b1; step(); host_rd = 1'b0;
    check("R4 pointer advanced", host_rdata, 32'h0000_0082);

    // R6 corrected pixel sweep
    tbl_off = 1'b0;
    for (int i = 0; i < 256; i++) begin
      pix_i = {8'(255 - i), 8'(i + 85), 8'(i)};
      pix_valid_i = i[0];
      step();
      check("R6 pixel", {8'h0, pix_o}, {8'h0, lut(pix_i)});
      check("R6 valid", {31'h0, pix_valid_o}, {31'h0, i[0]});
    end

    // R7 bypass sweep
    tbl_off = 1'b1;
    for (int i = 0; i < 256; i++) begin
      pix_i = {8'(i), ~8'(i), 8'(i) ^ 8'h33};
      step();
      check("R7 bypass", {8'h0, pix_o}, {8'h0, pix_i});
    end
    tbl_off = 1'b0;

    // R8 host access in the same dot cycle holds the output
    pa = 24'h10_20_30; pb = 24'h44_55_66; pc = 24'h9A_BC_DE;
    pix_i = pa; pix_valid_i = 1'b1; step();
    check("R6 before hold", {8'h0, pix_o}, {8'h0, lut(pa)});
    pix_i = pb; pix_valid_i = 1'b0; host_sel = 1'b1; host_rd = 1'b1; step(); host_rd = 1'b0;
    check("R8 held pixel", {8'h0, pix_o}, {8'h0, lut(pa)});
    check("R8 held valid", {31'h0, pix_valid_o}, 32'h1);
    step();
    check("R6 after hold", {8'h0, pix_o}, {8'h0, lut(pb)});
    check("R6 valid after hold", {31'h0, pix_valid_o}, 32'h0);

    // R9 idle dot period, with an access that must hold the next dot
    dot_en = 1'b0; host_rd = 1'b1; pix_i = pc; pix_valid_i = 1'b1; step(); host_rd = 1'b0;
    check("R9 idle pixel", {8'h0, pix_o}, {8'h0, lut(pb)});
    check("R9 idle valid", {31'h0, pix_valid_o}, 32'h0);
    step();
    check("R9 idle second", {8'h0, pix_o}, {8'h0, lut(pb)});
    dot_en = 1'b1; step();
    check("R8 pending hold", {8'h0, pix_o}, {8'h0, lut(pb)});
    step();
    check("R6 after pending", {8'h0, pix_o}, {8'h0, lut(pc)});
    check("R6 valid after pending", {31'h0, pix_valid_o}, 32'h1);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule